// File: doc/BRIEF.md
# Two-Wire Indexed Register Slave

This block is a serial slave on a two-wire bus (clock and open-drain data). It gives a host byte-wide access to a chip's register space through an index pointer. A host first writes the index. It can add one data byte in the same frame, or it can open a separate read frame later. A read returns the register that the pointer selects. The pointer never advances by itself, so repeated reads return the same location.

Most indices pass through to the rest of the chip over a simple port. The port has an index output, a one-cycle write strobe with data, and a combinational read-data input. The block answers a few locations itself:
- a set of fixed identification bytes;
- a test byte whose two upper bits control the input filtering and the bus timeout;
- a sticky flag inside index 0x05;
- the slave address register at 0xFF, protected by a key register at 0xFE.

Both bus lines pass through a synchroniser and a pulse-rejection filter. A watchdog returns the slave to idle if the clock is held low for too long.

States:
- ST_IDLE: waiting for a START.
- ST_ADDR: shifting in the address byte.
- ST_ADDR_ACK: acknowledging the address.
- ST_IDX and ST_IDX_ACK: receiving and acknowledging the index.
- ST_DATA and ST_DATA_ACK: receiving and acknowledging the data byte.
- ST_TX: sending a byte.
- ST_TX_ACK: sampling the host's acknowledge.
- ST_IGNORE: waiting for STOP or START.

Transitions:
- A START from any state goes to ST_ADDR. A STOP goes to ST_IDLE. A timeout goes to ST_IDLE.
- After eight address bits the slave goes to ST_ADDR_ACK on a match, and to ST_IGNORE otherwise.
- ST_ADDR_ACK goes to ST_TX for a read and to ST_IDX for a write.
- ST_IDX goes to ST_IDX_ACK, then to ST_DATA.
- ST_DATA goes to ST_DATA_ACK, then to ST_IGNORE.
- ST_TX goes to ST_TX_ACK. ST_TX_ACK goes back to ST_TX on a host acknowledge, and to ST_IGNORE on a not-acknowledge.

Top module: `i2c_idx_slave`

## Requirements
- R1: The first byte after a START is compared on bits [7:1] with bits [7:1] of the address register. Bit 0 is R/W, where 1 means read. On a match the slave pulls SDA low in the ninth clock. On a mismatch it never drives SDA until the next START.
- R2: A write frame that ends after the index byte loads the pointer (output reg_idx, reset value 0x00) and produces no write strobe.
- R3: In a write frame, the byte after the index is acknowledged and produces exactly one single-cycle reg_wr, with reg_idx and reg_wdata holding that index and byte. Any further byte in the same frame is not acknowledged and writes nothing.
- R4: A read frame returns the byte at the pointer. After a host acknowledge the same byte is sent again, because the pointer does not increment. After a host not-acknowledge SDA is released.
- R5: The identification bytes read 0x5A:0x03, 0x5B:0x02, 0x5C:0x12, 0x5D:0x19, 0x5E:0x34, 0x6A:0xA0 and 0x6B:0xA0. A write to any of them is acknowledged, produces no reg_wr and leaves the value unchanged.
- R6: The address register at index 0xFF resets to 0x5E, so the bus address after reset is 0x2F.
- R7: After 0xC9 is written to index 0xFE, the next write to 0xFF loads the address register. The new address is answered from the next frame on, and the old address is no longer answered.
- R8: A write to 0xFF is ignored unless the key is armed. The key is disarmed by the one write to 0xFF that it permits, and by any value other than 0xC9 written to 0xFE. Index 0xFE reads 0x00.
- R9: Bit 3 of index 0x05 reads 1 after reset. Writing 1 to that bit clears it, and writing 0 leaves it. The other bits of 0x05 come from reg_rdata, and the write is also passed on through reg_wr.
- R10: SCL or SDA pulses shorter than FILT_CYC clocks are ignored. When bit 7 of index 0xF0 is set, the filter is bypassed and such pulses act as bus edges.
- R11: In any state other than idle, if SCL stays low for TO_CYC clocks the slave returns to idle and releases SDA. Bit 6 of index 0xF0 disables this.
- R12: The slave only ever pulls SDA low, in acknowledge slots and in transmitted 0 bits, and it changes sda_oe only while the filtered SCL is low.
- R13: A repeated START in the middle of a frame restarts address reception. A STOP returns the slave to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_idx | output | 8 | Current index pointer |
| reg_wr | output | 1 | One-cycle write strobe to chip registers |
| reg_wdata | output | 8 | Write data for reg_wr |
| reg_rdata | input | 8 | Chip register value at reg_idx |

## Verification
Write frames are driven to external indices, to the identification bytes and to the address, key and test locations. A mismatch between the write-strobe count and the model separates pass-through writes from protected ones. Read frames are tried in several shapes:
- after a separate index write;
- after a repeated START;
- with a host acknowledge followed by a second byte.

Together these show whether the pointer holds, whether a restart parses correctly, and whether the slave resends the same byte. Key sequences are varied (armed, armed then wrong key, armed then used twice), and the address that answers afterwards tells the three cases apart. A short SCL pulse inside an index byte is sent with filtering on and then with it bypassed. Index corruption appears only in the bypassed case. A long clock-low hold while the slave drives a 0 is tried with the timeout enabled and then disabled.

// File: rtl/i2c_idx_pkg.sv
package i2c_idx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_IDX,
        ST_IDX_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } slv_state_t;

    localparam logic [7:0] IDX_FLAGS  = 8'h05;
    localparam logic [7:0] IDX_TEST   = 8'hF0;
    localparam logic [7:0] IDX_KEY    = 8'hFE;
    localparam logic [7:0] IDX_ADDR   = 8'hFF;
    localparam logic [7:0] KEY_VALUE  = 8'hC9;
    localparam logic [7:0] ADDR_RESET = 8'h5E;
    localparam int         FLAG_BIT   = 3;
    localparam int         BYP_BIT    = 7;
    localparam int         TMO_BIT    = 6;

    // {hit, value} for the fixed identification locations
    function automatic logic [8:0] id_lookup(input logic [7:0] idx);
        unique case (idx)
            8'h5A:        id_lookup = {1'b1, 8'h03};
            8'h5B:        id_lookup = {1'b1, 8'h02};
            8'h5C:        id_lookup = {1'b1, 8'h12};
            8'h5D:        id_lookup = {1'b1, 8'h19};
            8'h5E:        id_lookup = {1'b1, 8'h34};
            8'h6A, 8'h6B: id_lookup = {1'b1, 8'hA0};
            default:      id_lookup = {1'b0, 8'h00};
        endcase
    endfunction

    function automatic logic is_local(input logic [7:0] idx);
        is_local = id_lookup(idx)[8] || idx == IDX_TEST || idx == IDX_KEY || idx == IDX_ADDR;
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int FILT_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic bypass,
    output logic clean
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            clean  <= 1'b1;
            run_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (bypass) begin
                clean <= sync_q[1];
                run_q <= '0;
            end else if (sync_q[1] == clean) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_CYC - 1)) begin
                clean <= sync_q[1];
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_idx_regs.sv
module i2c_idx_regs
    import i2c_idx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_idx,
    input  logic [7:0] idx_in,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    input  logic [7:0] ext_rdata,
    output logic [7:0] idx,
    output logic [7:0] rdata,
    output logic [7:0] dev_addr,
    output logic       unlock,
    output logic       filt_byp,
    output logic       tmo_dis,
    output logic       ext_wr
);
    logic [7:0] test_q;
    logic       flag_q;
    logic [8:0] id_res;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx      <= '0;
            dev_addr <= ADDR_RESET;
            unlock   <= 1'b0;
            test_q   <= '0;
            flag_q   <= 1'b1;
        end else begin
            if (set_idx) idx <= idx_in;
            if (wr_stb) begin
                if (idx == IDX_KEY) begin
                    unlock <= (wr_data == KEY_VALUE);
                end
                if (idx == IDX_ADDR && unlock) begin
                    dev_addr <= wr_data;
                    unlock   <= 1'b0;
                end
                if (idx == IDX_TEST) test_q <= wr_data;
                if (idx == IDX_FLAGS && wr_data[FLAG_BIT]) flag_q <= 1'b0;
            end
        end
    end

    assign id_res   = id_lookup(idx);
    assign filt_byp = test_q[BYP_BIT];
    assign tmo_dis  = test_q[TMO_BIT];
    assign ext_wr   = wr_stb && !is_local(idx);

    always_comb begin
        if (id_res[8])             rdata = id_res[7:0];
        else if (idx == IDX_TEST)  rdata = test_q;
        else if (idx == IDX_KEY)   rdata = 8'h00;
        else if (idx == IDX_ADDR)  rdata = dev_addr;
        else if (idx == IDX_FLAGS) rdata = {ext_rdata[7:4], flag_q, ext_rdata[2:0]};
        else                       rdata = ext_rdata;
    end
endmodule

// File: rtl/i2c_idx_slave.sv
module i2c_idx_slave
    import i2c_idx_pkg::*;
#(
    parameter int FILT_CYC = 25,
    parameter int TO_CYC   = 3_125_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] reg_idx,
    output logic       reg_wr,
    output logic [7:0] reg_wdata,
    input  logic [7:0] reg_rdata
);
    localparam int BITS  = 8;
    localparam int CNT_W = $clog2(BITS + 1);
    localparam int TMO_W = $clog2(TO_CYC + 1);
    localparam int LINES = 2;

    slv_state_t       state, nxt;
    logic [LINES-1:0] ln_raw, ln_f;
    logic             scl_f, sda_f, scl_d, sda_d;
    logic             scl_rise, scl_fall, start_c, stop_c;
    logic [7:0]       sh_q, tx_q, wr_byte;
    logic [CNT_W-1:0] cnt_q;
    logic             rw_q, mack_q, wr_stb;
    logic [TMO_W-1:0] tmo_cnt;
    logic             tmo_hit;
    logic [7:0]       dev_addr, rdata;
    logic             unlock, filt_byp, tmo_dis, set_idx, byte_done;

    assign ln_raw = {sda_i, scl_i};

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            i2c_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
                .clk(clk), .rst_n(rst_n), .raw(ln_raw[g]),
                .bypass(filt_byp), .clean(ln_f[g])
            );
        end
    endgenerate

    assign scl_f = ln_f[0];
    assign sda_f = ln_f[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    assign scl_rise  = scl_f && !scl_d;
    assign scl_fall  = !scl_f && scl_d;
    assign start_c   = scl_f && scl_d && sda_d && !sda_f;
    assign stop_c    = scl_f && scl_d && !sda_d && sda_f;
    assign byte_done = scl_fall && (cnt_q == CNT_W'(BITS));
    assign set_idx   = (state == ST_IDX) && byte_done;
    assign tmo_hit   = (tmo_cnt == TMO_W'(TO_CYC));

    i2c_idx_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .set_idx(set_idx), .idx_in(sh_q),
        .wr_stb(wr_stb), .wr_data(wr_byte),
        .ext_rdata(reg_rdata),
        .idx(reg_idx), .rdata(rdata), .dev_addr(dev_addr),
        .unlock(unlock), .filt_byp(filt_byp), .tmo_dis(tmo_dis),
        .ext_wr(reg_wr)
    );
    assign reg_wdata = wr_byte;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (tmo_hit)      nxt = ST_IDLE;
        else if (stop_c)  nxt = ST_IDLE;
        else if (start_c) nxt = ST_ADDR;
        else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_done)
                                 nxt = (sh_q[7:1] == dev_addr[7:1]) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) nxt = rw_q ? ST_TX : ST_IDX;
                ST_IDX:      if (byte_done) nxt = ST_IDX_ACK;
                ST_IDX_ACK:  if (scl_fall) nxt = ST_DATA;
                ST_DATA:     if (byte_done) nxt = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) nxt = ST_IGNORE;
                ST_TX:       if (scl_fall && cnt_q == CNT_W'(BITS - 1)) nxt = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) nxt = mack_q ? ST_TX : ST_IGNORE;
                ST_IGNORE:   nxt = ST_IGNORE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // datapath: shifters, counters, strobe, watchdog
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            tx_q    <= '0;
            cnt_q   <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            wr_stb  <= 1'b0;
            wr_byte <= '0;
            tmo_cnt <= '0;
        end else begin
            wr_stb <= 1'b0;

            if (state == ST_IDLE || scl_f || tmo_dis) tmo_cnt <= '0;
            else if (!tmo_hit)                        tmo_cnt <= tmo_cnt + 1'b1;

            if (start_c) begin
                cnt_q <= '0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_IDX, ST_DATA: begin
                        if (scl_rise) begin
                            sh_q  <= {sh_q[6:0], sda_f};
                            cnt_q <= cnt_q + 1'b1;
                        end
                        if (byte_done && state == ST_ADDR) rw_q <= sh_q[0];
                        if (byte_done && state == ST_DATA) begin
                            wr_stb  <= 1'b1;
                            wr_byte <= sh_q;
                        end
                    end
                    ST_ADDR_ACK: if (scl_fall) begin
                        cnt_q <= '0;
                        tx_q  <= rdata;
                    end
                    ST_IDX_ACK: if (scl_fall) cnt_q <= '0;
                    ST_TX: if (scl_fall) begin
                        tx_q  <= {tx_q[6:0], 1'b1};
                        cnt_q <= cnt_q + 1'b1;
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) mack_q <= !sda_f;
                        if (scl_fall) begin
                            cnt_q <= '0;
                            tx_q  <= rdata;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_IDX_ACK, ST_DATA_ACK: sda_oe = 1'b1;
            ST_TX:                                sda_oe = !tx_q[7];
            default:                              sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2c_idx_slave_chk.sv
module i2c_idx_slave_chk
    import i2c_idx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input slv_state_t state,
    input logic       sda_oe,
    input logic       scl_f,
    input logic       reg_wr,
    input logic [7:0] reg_idx,
    input logic [7:0] dev_addr,
    input logic       unlock,
    input logic       tmo_hit
);
    p_idle_release_r13: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !sda_oe);

    p_drive_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);

    p_wr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    p_ro_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> !id_lookup(reg_idx)[8] && reg_idx != IDX_ADDR && reg_idx != IDX_KEY);

    p_addr_needs_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_addr) |-> $past(unlock));

    p_key_one_use_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_addr) |-> !unlock);

    p_timeout_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_hit |=> state == ST_IDLE);
endmodule

bind i2c_idx_slave i2c_idx_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .sda_oe(sda_oe), .scl_f(scl_f),
    .reg_wr(reg_wr), .reg_idx(reg_idx), .dev_addr(dev_addr),
    .unlock(unlock), .tmo_hit(tmo_hit)
);

// File: tb/i2c_idx_slave_bench.sv
module i2c_idx_slave_bench;
    localparam int H    = 20;
    localparam int FILT = 4;
    localparam int TO   = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, reg_wr;
    logic [7:0] reg_idx, reg_wdata, reg_rdata;
    wire sda_ln = sda_m & ~sda_oe;

    int tests = 0, fails = 0, wr_cnt = 0;
    logic [7:0] last_idx, last_dat;
    logic [7:0] m_addr = 8'h5E, m_f0 = 8'h00;
    logic m_flag = 1'b1;

    always #4 clk = ~clk;

    assign reg_rdata = reg_idx ^ 8'hA5;

    i2c_idx_slave #(.FILT_CYC(FILT), .TO_CYC(TO)) u_i2c_idx_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_ln), .sda_oe(sda_oe),
        .reg_idx(reg_idx), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always @(posedge clk) if (reg_wr) begin
        wr_cnt   <= wr_cnt + 1;
        last_idx <= reg_idx;
        last_dat <= reg_wdata;
    end

    function automatic logic is_special(input logic [7:0] i);
        return i == 8'h05 || (i >= 8'h5A && i <= 8'h5E) || i == 8'h6A || i == 8'h6B
            || i == 8'hF0 || i == 8'hFE || i == 8'hFF;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] i);
        logic [7:0] e;
        e = i ^ 8'hA5;
        case (i)
            8'h5A: return 8'h03;
            8'h5B: return 8'h02;
            8'h5C: return 8'h12;
            8'h5D: return 8'h19;
            8'h5E: return 8'h34;
            8'h6A, 8'h6B: return 8'hA0;
            8'hF0: return m_f0;
            8'hFE: return 8'h00;
            8'hFF: return m_addr;
            8'h05: return {e[7:4], m_flag, e[2:0]};
            default: return e;
        endcase
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_w(input logic b);
        sda_m = b; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(2);
    endtask

    task automatic bit_r(output logic b);
        sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H/2); b = sda_ln; wt(H/2); scl_m = 1'b0; wt(2);
    endtask

    task automatic start_c;
        sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(2);
    endtask

    task automatic stop_c;
        sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_w(d[i]);
        bit_r(a);
        ack = !a;
    endtask

    task automatic wbyte_glitch(input logic [7:0] d, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) begin
            bit_w(d[i]);
            if (i == 3) begin
                scl_m = 1'b1; wt(2); scl_m = 1'b0; wt(2);
            end
        end
        bit_r(a);
        ack = !a;
    endtask

    task automatic rbyte(output logic [7:0] d, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_r(b);
            d[i] = b;
        end
        bit_w(!mack);
    endtask

    task automatic wr_reg(input logic [7:0] i, input logic [7:0] d, output logic ok);
        logic a0, a1, a2;
        start_c; wbyte({m_addr[7:1], 1'b0}, a0); wbyte(i, a1); wbyte(d, a2); stop_c;
        ok = a0 && a1 && a2;
    endtask

    task automatic set_ptr(input logic [7:0] i);
        logic a0, a1;
        start_c; wbyte({m_addr[7:1], 1'b0}, a0); wbyte(i, a1); stop_c;
    endtask

    task automatic rd_cur(output logic [7:0] d);
        logic a;
        start_c; wbyte({m_addr[7:1], 1'b1}, a);
        if (a) rbyte(d, 1'b0); else d = 8'hXX;
        stop_c;
    endtask

    task automatic rd_reg(input logic [7:0] i, output logic [7:0] d);
        set_ptr(i); rd_cur(d);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] d, d2, i, v;
        logic a, a0, a1, a2, a3, ok;
        int pre;
        int unsigned seed;
        seed = $urandom(32'd715);

        wt(5); rst_n = 1'b1; wt(5);
        chk(sda_oe == 1'b0, "R13 reset sda_oe", int'(sda_oe), 0);
        chk(reg_wr == 1'b0, "R3 reset reg_wr", int'(reg_wr), 0);
        chk(reg_idx == 8'h00, "R2 reset index", reg_idx, 0);

        rd_reg(8'hFF, d); chk(d == 8'h5E, "R6 address reset", d, 8'h5E);
        rd_reg(8'h05, d); chk(d == exp_rd(8'h05), "R9 flag after reset", d, exp_rd(8'h05));

        // R1 mismatched address
        start_c; wbyte({7'h30, 1'b0}, a); stop_c;
        chk(!a, "R1 foreign address not acked", a, 0);

        // R2 index-only write
        pre = wr_cnt; set_ptr(8'h33); wt(4);
        chk(reg_idx == 8'h33, "R2 pointer set", reg_idx, 8'h33);
        chk(wr_cnt == pre, "R2 no strobe", wr_cnt, pre);

        // R3 data write plus extra byte
        pre = wr_cnt;
        start_c; wbyte({m_addr[7:1], 1'b0}, a0); wbyte(8'h40, a1); wbyte(8'h77, a2); wbyte(8'h55, a3); stop_c;
        chk(a0 && a1 && a2, "R3 acks", {a0, a1, a2}, 7);
        chk(!a3, "R3 extra byte nack", a3, 0);
        chk(wr_cnt == pre + 1, "R3 one strobe", wr_cnt, pre + 1);
        chk(last_idx == 8'h40 && last_dat == 8'h77, "R3 strobe content", {last_idx, last_dat}, 16'h4077);

        // R4 repeated read without increment
        set_ptr(8'h5C);
        start_c; wbyte({m_addr[7:1], 1'b1}, a); rbyte(d, 1'b1); rbyte(d2, 1'b0); stop_c;
        chk(d == 8'h12 && d2 == 8'h12, "R4 resend same byte", {d, d2}, 16'h1212);
        rd_cur(d); chk(d == 8'h12, "R4 pointer holds", d, 8'h12);
        chk(sda_oe == 1'b0, "R4 released after nack", sda_oe, 0);

        // R13 repeated start
        start_c; wbyte({m_addr[7:1], 1'b0}, a); wbyte(8'h5D, a);
        start_c; wbyte({m_addr[7:1], 1'b1}, a); rbyte(d, 1'b0); stop_c;
        chk(d == 8'h19, "R13 repeated start read", d, 8'h19);
        wt(10); chk(sda_oe == 1'b0, "R13 stop releases", sda_oe, 0);

        // R5 read-only write
        pre = wr_cnt; wr_reg(8'h5E, 8'hFF, ok);
        chk(ok, "R5 ro write acked", ok, 1);
        chk(wr_cnt == pre, "R5 ro no strobe", wr_cnt, pre);
        rd_reg(8'h5E, d); chk(d == 8'h34, "R5 ro unchanged", d, 8'h34);

        // R7 unlock and new address
        wr_reg(8'hFE, 8'hC9, ok); wr_reg(8'hFF, 8'h64, ok);
        start_c; wbyte({7'h2F, 1'b0}, a); stop_c;
        chk(!a, "R7 old address dropped", a, 0);
        m_addr = 8'h64;
        rd_reg(8'hFF, d); chk(d == 8'h64, "R7 new address", d, 8'h64);

        // R8 lock cases
        wr_reg(8'hFF, 8'h5E, ok); rd_reg(8'hFF, d);
        chk(d == 8'h64, "R8 no key", d, 8'h64);
        wr_reg(8'hFE, 8'hC9, ok); wr_reg(8'hFE, 8'h11, ok); wr_reg(8'hFF, 8'h5E, ok);
        rd_reg(8'hFF, d); chk(d == 8'h64, "R8 wrong key disarms", d, 8'h64);
        rd_reg(8'hFE, d); chk(d == 8'h00, "R8 key reads zero", d, 0);
        wr_reg(8'hFE, 8'hC9, ok); wr_reg(8'hFF, 8'h5E, ok); m_addr = 8'h5E;
        wr_reg(8'hFF, 8'h20, ok); rd_reg(8'hFF, d);
        chk(d == 8'h5E, "R8 single use", d, 8'h5E);

        // R9 flag
        pre = wr_cnt; wr_reg(8'h05, 8'h00, ok); rd_reg(8'h05, d);
        chk(d == exp_rd(8'h05), "R9 write 0 keeps", d, exp_rd(8'h05));
        chk(wr_cnt == pre + 1, "R9 passed on", wr_cnt, pre + 1);
        wr_reg(8'h05, 8'h08, ok); m_flag = 1'b0; rd_reg(8'h05, d);
        chk(d == exp_rd(8'h05), "R9 write 1 clears", d, exp_rd(8'h05));

        // R10 glitch filter then bypass
        start_c; wbyte({m_addr[7:1], 1'b0}, a); wbyte_glitch(8'h5A, a); stop_c; wt(4);
        chk(reg_idx == 8'h5A, "R10 glitch rejected", reg_idx, 8'h5A);
        wr_reg(8'hF0, 8'h80, ok); m_f0 = 8'h80;
        start_c; wbyte({m_addr[7:1], 1'b0}, a); wbyte_glitch(8'h5A, a); stop_c; wt(4);
        chk(reg_idx == 8'h5D, "R10 bypass lets glitch in", reg_idx, 8'h5D);
        wr_reg(8'hF0, 8'h00, ok); m_f0 = 8'h00;
        rd_reg(8'hF0, d); chk(d == 8'h00, "R10 test reg restored", d, 0);

        // R11 timeout enabled
        set_ptr(8'h5A);
        start_c; wbyte({m_addr[7:1], 1'b1}, a); wt(10);
        chk(sda_oe == 1'b1, "R12 driving a 0 bit", sda_oe, 1);
        wt(TO + 200);
        chk(sda_oe == 1'b0, "R11 timeout releases", sda_oe, 0);
        stop_c;
        // R11 timeout disabled
        wr_reg(8'hF0, 8'h40, ok); m_f0 = 8'h40;
        set_ptr(8'h5A);
        start_c; wbyte({m_addr[7:1], 1'b1}, a); wt(TO + 200);
        chk(sda_oe == 1'b1, "R11 disabled holds", sda_oe, 1);
        rbyte(d, 1'b0); stop_c;
        chk(d == 8'h03, "R11 byte intact", d, 8'h03);
        wr_reg(8'hF0, 8'h00, ok); m_f0 = 8'h00;

        // random mix
        for (int n = 0; n < 30; n++) begin
            int op;
            op = $urandom_range(2);
            if (op == 0) begin
                do i = 8'($urandom); while (is_special(i));
                v = 8'($urandom);
                pre = wr_cnt; wr_reg(i, v, ok); wt(4);
                chk(ok && wr_cnt == pre + 1, "R3 random write strobe", wr_cnt, pre + 1);
                chk(last_idx == i && last_dat == v, "R3 random write content", {last_idx, last_dat}, {i, v});
            end else if (op == 1) begin
                i = 8'($urandom);
                rd_reg(i, d);
                chk(d == exp_rd(i), "R4 random read", d, exp_rd(i));
            end else begin
                case ($urandom_range(6))
                    0: i = 8'h5A; 1: i = 8'h5B; 2: i = 8'h5C; 3: i = 8'h5D;
                    4: i = 8'h5E; 5: i = 8'h6A; default: i = 8'h6B;
                endcase
                pre = wr_cnt; wr_reg(i, 8'($urandom), ok); rd_reg(i, d);
                chk(wr_cnt == pre && d == exp_rd(i), "R5 random ro write", d, exp_rd(i));
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule